// File: doc/BRIEF.md
# Nibble Register File with Condition Flags

This block holds the programmer-visible state of a 4-bit microcontroller core: an accumulator, a sub-accumulator, two RAM address registers (row and digit), a shadow register for each address register, two scratch registers, a carry flag and a condition flag. Each cycle a decoded micro-operation code and an operand selector arrive from the instruction decoder. The ALU result, overflow and flag buses arrive from the ALU. The block applies the operation in one clock edge and presents every register at its outputs.

The condition flag gates conditional instructions such as branch, call and table load. The block raises `cond_go` combinationally when a conditional operation is presented and the flag is set. When a conditional operation finds the flag clear, the instruction is skipped and the flag re-arms to 1. The digit register has a side stepper that counts up or down in the same cycle as another transfer. This lets the core walk through multi-digit operands.

Top module: `nibble_regfile`

## Requirements
- R1: On reset (`rst_n` low), all eight 4-bit registers clear to 0, `carry` clears to 0 and `status` sets to 1.
- R2: The ALU loads `alu_res` into the destination named by `op`, as follows. Op 1 loads `acc` and also loads `alu_ovf` into `carry`. Op 2 loads `bacc`. Op 3 loads `xrow`. Op 4 loads `ydig`.
- R3: Op 5 loads `alu_flag` (a not-zero, overflow or bit-test result) into `status`. Op 6 sets `carry`. Op 7 clears `carry`. Op 8 copies `carry` into `status`.
- R4: Op 9 rotates the 5-bit value {carry, acc} left: `carry` takes acc bit 3, and acc bit 0 takes the old `carry`. Op 10 rotates it right: `carry` takes acc bit 0, and acc bit 3 takes the old `carry`.
- R5: Op 11 swaps `xrow` with `xshadow`. Op 12 swaps `ydig` with `yshadow`.
- R6: Op 15 copies a source into a scratch register. The source is `acc` when `sel[1]`=0 and `bacc` when `sel[1]`=1. The destination is `scr4` when `sel[0]`=0 and `scr5` when `sel[0]`=1. Op 16 is the reverse copy: `scr4` or `scr5` (chosen by `sel[0]`) goes into `acc` or `bacc` (chosen by `sel[1]`).
- R7: `ystep` values: 1 increments `ydig` modulo 16, and 2 decrements it modulo 16. The stepped `ydig` applies in the same cycle as any op that does not write `ydig`. In that case `status` also takes (new `ydig` != 0), unless the op itself writes `status` (ops 5, 8, 17). When the op writes `ydig` (ops 4, 12), the step is ignored, including its effect on `status`. A `ystep` of 0 or 3 has no effect.
- R8: Op 17 is a conditional instruction. `cond_go` is 1 exactly when `op`=17 and `status`=1. When `op`=17 and `status`=0, `status` becomes 1 at the clock edge.
- R9: Op 0 and ops 13, 14 and 18 through 31 change no register or flag. Every op leaves unchanged the registers it does not name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Decoded micro-operation code |
| sel | input | 2 | Operand selector for scratch transfers |
| ystep | input | 2 | Digit register step: 0 none, 1 up, 2 down |
| alu_res | input | 4 | ALU result nibble |
| alu_ovf | input | 1 | ALU overflow |
| alu_flag | input | 1 | ALU not-zero / overflow / bit-test result |
| acc | output | 4 | Accumulator |
| bacc | output | 4 | Sub-accumulator |
| xrow | output | 4 | RAM row address |
| ydig | output | 4 | RAM digit address |
| xshadow | output | 4 | Shadow of the row address |
| yshadow | output | 4 | Shadow of the digit address |
| scr4 | output | 4 | Scratch register 4 |
| scr5 | output | 4 | Scratch register 5 |
| carry | output | 1 | Carry flag |
| status | output | 1 | Condition flag |
| cond_go | output | 1 | Conditional instruction executes |

## Verification
The assertions check four behaviours on every cycle: rotate results, the swap symmetry of both address pairs, the re-arm of a skipped conditional, and the wrapping step of the digit register when no other write competes. The bench's scenarios cover the reset values and the precedence between an op and the stepper. They also cover the rule that ops leave unnamed registers untouched. A behavioural model compares every output after every clock across directed and pseudo-random op streams.

// File: rtl/nibble_regfile.sv
module nibble_regfile #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   op,
  input  logic [1:0]   sel,
  input  logic [1:0]   ystep,
  input  logic [W-1:0] alu_res,
  input  logic         alu_ovf,
  input  logic         alu_flag,
  output logic [W-1:0] acc,
  output logic [W-1:0] bacc,
  output logic [W-1:0] xrow,
  output logic [W-1:0] ydig,
  output logic [W-1:0] xshadow,
  output logic [W-1:0] yshadow,
  output logic [W-1:0] scr4,
  output logic [W-1:0] scr5,
  output logic         carry,
  output logic         status,
  output logic         cond_go
);

  localparam logic [4:0] OP_LDA = 5'd1,  OP_LDB = 5'd2,  OP_LDX = 5'd3,  OP_LDY = 5'd4;
  localparam logic [4:0] OP_STF = 5'd5,  OP_SEC = 5'd6,  OP_CLC = 5'd7,  OP_TSC = 5'd8;
  localparam logic [4:0] OP_ROL = 5'd9,  OP_ROR = 5'd10, OP_XCX = 5'd11, OP_XCY = 5'd12;
  localparam logic [4:0] OP_TOR = 5'd15, OP_FRR = 5'd16, OP_CND = 5'd17;

  logic         op_wr_y, op_wr_s, step_en;
  logic [W-1:0] y_stepped, scr_pick;

  assign op_wr_y   = (op == OP_LDY) || (op == OP_XCY);
  assign op_wr_s   = (op == OP_STF) || (op == OP_TSC) || (op == OP_CND);
  assign step_en   = !op_wr_y && (ystep == 2'd1 || ystep == 2'd2);
  assign y_stepped = (ystep == 2'd1) ? ydig + 1'b1 : ydig - 1'b1;
  assign scr_pick  = sel[0] ? scr5 : scr4;
  assign cond_go   = (op == OP_CND) && status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; bacc <= '0; xrow <= '0; ydig <= '0;
      xshadow <= '0; yshadow <= '0; scr4 <= '0; scr5 <= '0;
      carry <= 1'b0; status <= 1'b1;
    end else begin
      if (step_en) begin
        ydig <= y_stepped;
        if (!op_wr_s) status <= (y_stepped != '0);
      end
      case (op)
        OP_LDA: begin acc <= alu_res; carry <= alu_ovf; end
        OP_LDB: bacc <= alu_res;
        OP_LDX: xrow <= alu_res;
        OP_LDY: ydig <= alu_res;
        OP_STF: status <= alu_flag;
        OP_SEC: carry <= 1'b1;
        OP_CLC: carry <= 1'b0;
        OP_TSC: status <= carry;
        OP_ROL: begin acc <= {acc[W-2:0], carry}; carry <= acc[W-1]; end
        OP_ROR: begin acc <= {carry, acc[W-1:1]}; carry <= acc[0]; end
        OP_XCX: begin xrow <= xshadow; xshadow <= xrow; end
        OP_XCY: begin ydig <= yshadow; yshadow <= ydig; end
        OP_TOR: begin
          if (sel[0]) scr5 <= sel[1] ? bacc : acc;
          else        scr4 <= sel[1] ? bacc : acc;
        end
        OP_FRR: begin
          if (sel[1]) bacc <= scr_pick;
          else        acc  <= scr_pick;
        end
        OP_CND: if (!status) status <= 1'b1;
        default: ;
      endcase
    end
  end

  // R4
  rotate_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ROL |=> {acc, carry} == {$past(acc[W-2:0]), $past(carry), $past(acc[W-1])});
  // R4
  rotate_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ROR |=> {carry, acc} == {$past(acc[0]), $past(carry), $past(acc[W-1:1])});
  // R5
  swap_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XCX |=> xrow == $past(xshadow) && xshadow == $past(xrow));
  // R5
  swap_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XCY |=> ydig == $past(yshadow) && yshadow == $past(ydig));
  // R8
  skip_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CND && !status) |=> status);
  // R7
  ystep_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ystep == 2'd1 && op != OP_LDY && op != OP_XCY) |=> ydig == W'($past(ydig) + 1));
  // R7
  ystep_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ystep == 2'd2 && op != OP_LDY && op != OP_XCY) |=> ydig == W'($past(ydig) - 1));

endmodule

// File: tb/test_nibble_regfile.sv
`timescale 1ns/1ps
module test_nibble_regfile;
  logic clk = 0, rst_n = 0;
  logic [4:0] op = 0;
  logic [1:0] sel = 0, ystep = 0;
  logic [3:0] alu_res = 0;
  logic alu_ovf = 0, alu_flag = 0;
  logic [3:0] acc, bacc, xrow, ydig, xshadow, yshadow, scr4, scr5;
  logic carry, status, cond_go;

  int compared = 0, mismatched = 0;
  int ma, mb, mx, my, msx, msy, m4, m5, mc, ms;

  always #2.5 clk = ~clk;

  nibble_regfile i_nibble_regfile (.*);

  task automatic chk(input string req, input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic string tag_of(input int o, input int ys);
    if (o == 1 || o == 2 || o == 3 || o == 4) return "R2";
    if (o >= 5 && o <= 8) return "R3";
    if (o == 9 || o == 10) return "R4";
    if (o == 11 || o == 12) return "R5";
    if (o == 15 || o == 16) return "R6";
    if (o == 17) return "R8";
    if (ys == 1 || ys == 2) return "R7";
    return "R9";
  endfunction

  task automatic cmp_all(input string r);
    chk(r, "acc", acc, ma);      chk(r, "bacc", bacc, mb);
    chk(r, "xrow", xrow, mx);    chk(r, "ydig", ydig, my);
    chk(r, "xshadow", xshadow, msx); chk(r, "yshadow", yshadow, msy);
    chk(r, "scr4", scr4, m4);    chk(r, "scr5", scr5, m5);
    chk(r, "carry", carry, mc);  chk(r, "status", status, ms);
  endtask

  task automatic step(input int o, input int s, input int ys, input int res, input int ovf, input int fl);
    int na, nb, nx, ny, nsx, nsy, n4, n5, nc, ns, src;
    op = 5'(o); sel = 2'(s); ystep = 2'(ys); alu_res = 4'(res); alu_ovf = ovf[0]; alu_flag = fl[0];
    #1;
    chk("R8", "cond_go", cond_go, (o == 17 && ms == 1) ? 1 : 0);
    na = ma; nb = mb; nx = mx; ny = my; nsx = msx; nsy = msy; n4 = m4; n5 = m5; nc = mc; ns = ms;
    if (o != 4 && o != 12 && (ys == 1 || ys == 2)) begin
      ny = (ys == 1) ? (my + 1) % 16 : (my + 15) % 16;
      if (o != 5 && o != 8 && o != 17) ns = (ny != 0);
    end
    src = s[1] ? mb : ma;
    case (o)
      1: begin na = res; nc = ovf; end
      2: nb = res;
      3: nx = res;
      4: ny = res;
      5: ns = fl;
      6: nc = 1;
      7: nc = 0;
      8: ns = mc;
      9: begin na = ((ma * 2) % 16) + mc; nc = ma / 8; end
      10: begin na = mc * 8 + ma / 2; nc = ma % 2; end
      11: begin nx = msx; nsx = mx; end
      12: begin ny = msy; nsy = my; end
      15: if (s[0]) n5 = src; else n4 = src;
      16: if (s[1]) nb = s[0] ? m5 : m4; else na = s[0] ? m5 : m4;
      17: if (ms == 0) ns = 1;
      default: ;
    endcase
    @(posedge clk);
    ma = na; mb = nb; mx = nx; my = ny; msx = nsx; msy = nsy; m4 = n4; m5 = n5; mc = nc; ms = ns;
    @(negedge clk);
    cmp_all(tag_of(o, ys));
  endtask

  initial begin
    #(5.0 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    ma = 0; mb = 0; mx = 0; my = 0; msx = 0; msy = 0; m4 = 0; m5 = 0; mc = 0; ms = 1;
    repeat (3) @(negedge clk);
    cmp_all("R1");
    rst_n = 1;
    @(negedge clk);
    step(1, 0, 0, 4'hA, 1, 0);   // R2 acc + carry
    step(2, 0, 0, 4'h5, 0, 0);   // R2
    step(3, 0, 0, 4'h3, 0, 0);   // R2
    step(4, 0, 0, 4'hF, 0, 0);   // R2
    step(9, 0, 0, 0, 0, 0);      // R4 rotate left
    step(10, 0, 0, 0, 0, 0);     // R4 rotate right
    step(10, 0, 0, 0, 0, 0);
    step(11, 0, 0, 0, 0, 0);     // R5
    step(12, 0, 0, 0, 0, 0);     // R5
    step(12, 0, 1, 0, 0, 0);     // R5 swap wins over step (R7)
    step(15, 2'b01, 0, 0, 0, 0); // R6 acc -> scr5
    step(15, 2'b10, 0, 0, 0, 0); // R6 bacc -> scr4
    step(16, 2'b11, 0, 0, 0, 0); // R6 scr5 -> bacc
    step(7, 0, 0, 0, 0, 0);      // R3 clear carry
    step(8, 0, 0, 0, 0, 0);      // R3 status <- carry (0)
    step(17, 0, 0, 0, 0, 0);     // R8 skip and re-arm
    step(17, 0, 0, 0, 0, 0);     // R8 execute
    step(4, 0, 0, 4'hF, 0, 0);
    step(0, 0, 1, 0, 0, 0);      // R7 wrap to 0, status 0
    step(0, 0, 2, 0, 0, 0);      // R7 wrap to 15
    step(5, 0, 1, 0, 0, 0);      // R7 op status write wins
    step(0, 0, 3, 0, 0, 0);      // R7 no effect
    step(13, 0, 0, 4'h7, 1, 1);  // R9
    step(31, 3, 0, 4'h7, 1, 1);  // R9
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 31), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1));
    rst_n = 0;
    ma = 0; mb = 0; mx = 0; my = 0; msx = 0; msy = 0; m4 = 0; m5 = 0; mc = 0; ms = 1;
    @(negedge clk);
    cmp_all("R1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule